// File: doc/BRIEF.md
# Mesh Router with Crossbar-Free Backup Path

This block is a five-port wormhole router for one node of a 2-D mesh. Its ports face east (X+), west (X-), north (Y+), south (Y-) and the local core. Each input has a small flit buffer and a route stage. Each output has a round-robin arbiter and takes data from a 5x5 crossbar. Heads are routed in dimension order, X first and then Y. An output stays locked to the winning input until that packet's last flit has left.

A fault vector marks dead crossbar paths, one bit per output, plus one bit for the local network interface. Some paths have failed. The westward ring input can still reach the eastward output through a dedicated three-way output multiplexer that never touches the crossbar, and the local core can reach that output the same way. The westward ring input can also reach the core through a two-way multiplexer placed ahead of the core output. Together these paths give the core one way out and one way in, whichever single module has failed. A head whose dimension-order output is dead is diverted onto the eastward ring output.

Top module: `dbp_router`

## Requirements
- R1: After reset every `out_valid_o` bit is low and every `in_ready_o` bit is high.
- R2: Flit bits [63:62] give the kind: 00 single, 01 head, 10 body, 11 tail. Head bits [61:58] give the destination X and bits [57:54] the destination Y. Output index 0 is X+, 1 is X-, 2 is Y+, 3 is Y- and 4 is local. With no fault, the head leaves on output 0 if its X is larger than the node's, on output 1 if smaller, and otherwise on output 2, 3 or 4 as its Y is larger, smaller or equal.
- R3: Once a head wins an output, that output carries only that packet's flits, unchanged, until its single or tail flit, and each input holds at most one output at a time.
- R4: Every accepted flit leaves exactly once, and flits from one input to one output keep their order.
- R5: With the crossbar path to X+ dead, packets from the X- input and from the local input that are bound for X+ still leave intact on X+, through the backup multiplexer. The backup path is engaged only at an output whose crossbar path or interface is marked dead.
- R6: With the local interface marked dead, every packet from the local input leaves on X+ by the backup path. X- packets addressed to this node still reach the local output, and packets from any other input addressed to this node go to X+.
- R7: A head whose dimension-order output other than X+ has a dead crossbar path is diverted to X+.
- R8: With the crossbar path to the local output dead, X- packets addressed to this node are delivered on the local output through the bypass multiplexer.
- R9: Each input buffers up to DEPTH flits (4 by default) and drops `in_ready_o` while full. No flit is lost while an input waits behind a held output.
- R10: When a head on the X- input and a head on the local input both wait for a free X+ output, the X- packet is granted first.
- R11: The fault vector may change only while all buffers are empty and no output is held. A new value applies to every head that arrives afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NP+1 | Bits 0..4: crossbar path to that output dead; bit 5: local interface dead |
| in_valid_i | input | NP | Flit offered on each input |
| in_data_i | input | NP*FLIT_W | Flits, input k at bits [k*64 +: 64] |
| in_ready_o | output | NP | Input buffer can take a flit |
| out_valid_o | output | NP | Flit present on each output |
| out_data_o | output | NP*FLIT_W | Output flits, output k at bits [k*64 +: 64] |

## Verification
The assertions assume that the fault vector changes only while the router is idle, that at most one fault bit is set, and that every packet on an input is well formed: a single flit, or a head, any bodies and a tail. They also assume that while the X+ crossbar path is dead, no packet from the X+, Y+ or Y- inputs targets X+, because such a packet has no route left. The stimulus waits for the router to drain before it changes the fault vector, sets one fault at a time, always ends a packet with its tail, and redraws any destination that would break the X+ restriction. A behavioural scoreboard predicts each flit's output from the requirement rules.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    localparam int NP   = 5;
    localparam int PXP  = 0;
    localparam int PXM  = 1;
    localparam int PYP  = 2;
    localparam int PYM  = 3;
    localparam int PLOC = 4;

    typedef enum logic [1:0] {
        K_SINGLE = 2'b00,
        K_HEAD   = 2'b01,
        K_BODY   = 2'b10,
        K_TAIL   = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        SEL_XBAR = 2'd0,
        SEL_RING = 2'd1,
        SEL_INJ  = 2'd2
    } ring_sel_e;

    function automatic logic starts_pkt(input logic [1:0] k);
        return (k == K_SINGLE) || (k == K_HEAD);
    endfunction

    function automatic logic ends_pkt(input logic [1:0] k);
        return (k == K_SINGLE) || (k == K_TAIL);
    endfunction

endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         full_o,
    output logic         empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wp] = din_i;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop_i) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        if (push_i && !pop_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_i && !push_i) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o  = st_q.mem[st_q.rp];
    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);

    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o); // R9

endmodule

// File: rtl/rtr_route.sv
module rtr_route
    import rtr_pkg::*;
#(
    parameter int SRC     = 0,
    parameter int FLIT_W  = 64,
    parameter int COORD_W = 4,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2,
    localparam int IW     = $clog2(NP)
) (
    input  logic [NP:0]       fault_i,
    input  logic [FLIT_W-1:0] flit_i,
    output logic [IW-1:0]     out_o,
    output logic              byp_o
);

    localparam int XHI = FLIT_W - 3;
    localparam int YHI = FLIT_W - 3 - COORD_W;

    logic [COORD_W-1:0] dx, dy;
    logic [IW-1:0]      xy;
    logic               blocked;

    always_comb begin
        dx = flit_i[XHI -: COORD_W];
        dy = flit_i[YHI -: COORD_W];
        if (dx > COORD_W'(MY_X))      xy = IW'(PXP);
        else if (dx < COORD_W'(MY_X)) xy = IW'(PXM);
        else if (dy > COORD_W'(MY_Y)) xy = IW'(PYP);
        else if (dy < COORD_W'(MY_Y)) xy = IW'(PYM);
        else                          xy = IW'(PLOC);

        blocked = fault_i[xy] || (fault_i[NP] && ((SRC == PLOC) || (xy == IW'(PLOC))));

        if (!blocked) begin
            out_o = xy;
            byp_o = 1'b0;
        end else if ((SRC == PXM) && (xy == IW'(PLOC))) begin
            out_o = IW'(PLOC);
            byp_o = 1'b1;
        end else if (SRC == PXM) begin
            out_o = IW'(PXP);
            byp_o = fault_i[PXP];
        end else if (SRC == PLOC) begin
            out_o = IW'(PXP);
            byp_o = fault_i[PXP] || fault_i[NP];
        end else begin
            out_o = IW'(PXP);
            byp_o = 1'b0;
        end
    end

endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
    parameter int N   = 5,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic          gnt_any_o,
    output logic [IW-1:0] gnt_idx_o
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        gnt_any_o = 1'b0;
        gnt_idx_o = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(st_q.ptr) + k) % N;
            if (!gnt_any_o && req_i[c]) begin
                gnt_any_o = 1'b1;
                gnt_idx_o = IW'(c);
            end
        end
        if (gnt_any_o) begin
            st_d.ptr = (gnt_idx_o == IW'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dbp_router.sv
module dbp_router
    import rtr_pkg::*;
#(
    parameter int FLIT_W  = 64,
    parameter int DEPTH   = 4,
    parameter int COORD_W = 4,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP:0]          fault_i,
    input  logic [NP-1:0]        in_valid_i,
    input  logic [NP*FLIT_W-1:0] in_data_i,
    output logic [NP-1:0]        in_ready_o,
    output logic [NP-1:0]        out_valid_o,
    output logic [NP*FLIT_W-1:0] out_data_o
);

    localparam int IW = $clog2(NP);

    typedef struct packed {
        logic [NP-1:0][IW-1:0]     owner;
        logic [NP-1:0]             busy;
        logic [NP-1:0]             byp;
        logic [NP-1:0]             ov;
        logic [NP-1:0][FLIT_W-1:0] od;
    } rtr_st_t;

    rtr_st_t st_q, st_d;

    logic [NP-1:0][FLIT_W-1:0] head;
    logic [NP-1:0]             empty, full, pop;
    logic [NP-1:0][IW-1:0]     r_out;
    logic [NP-1:0]             r_byp;
    logic [NP-1:0][NP-1:0]     own_m;
    logic [NP-1:0]             active, head_ok;
    logic [NP-1:0][NP-1:0]     req;
    logic [NP-1:0]             gnt_any;
    logic [NP-1:0][IW-1:0]     gnt_idx;
    logic                      idle;

    // Per-input buffer and route stage
    for (genvar g = 0; g < NP; g++) begin : g_in
        rtr_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (in_valid_i[g] && !full[g]),
            .din_i   (in_data_i[g*FLIT_W +: FLIT_W]),
            .pop_i   (pop[g]),
            .dout_o  (head[g]),
            .full_o  (full[g]),
            .empty_o (empty[g])
        );
        assign in_ready_o[g] = !full[g];

        rtr_route #(
            .SRC(g), .FLIT_W(FLIT_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)
        ) u_route (
            .fault_i (fault_i),
            .flit_i  (head[g]),
            .out_o   (r_out[g]),
            .byp_o   (r_byp[g])
        );
    end

    // Request matrix: free outputs, unheld heads; ring beats injection on X+
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                own_m[i][o] = st_q.busy[o] && (st_q.owner[o] == IW'(i));
            end
            active[i]  = |own_m[i];
            head_ok[i] = !empty[i] && starts_pkt(head[i][FLIT_W-1 -: 2]) && !active[i];
        end
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req[o][i] = head_ok[i] && (r_out[i] == IW'(o)) && !st_q.busy[o];
            end
        end
        req[PXP][PLOC] = req[PXP][PLOC] && !req[PXP][PXM];
    end

    for (genvar g = 0; g < NP; g++) begin : g_out
        rtr_rr_arb #(.N(NP)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req[g]),
            .gnt_any_o (gnt_any[g]),
            .gnt_idx_o (gnt_idx[g])
        );
    end

    // Crossbar, backup multiplexers and output locks
    always_comb begin
        logic [IW-1:0]     src;
        logic [FLIT_W-1:0] sd, xb, od;
        logic              dead;
        ring_sel_e         rsel;

        st_d    = st_q;
        st_d.ov = '0;
        pop     = '0;
        for (int o = 0; o < NP; o++) begin
            src  = st_q.owner[o];
            sd   = head[src];
            dead = fault_i[o] || (fault_i[NP] && ((o == PLOC) || (src == IW'(PLOC))));
            xb   = dead ? '0 : sd;
            od   = xb;
            rsel = SEL_XBAR;
            if (o == PXP) begin
                if (!st_q.byp[o])           rsel = SEL_XBAR;
                else if (src == IW'(PXM))   rsel = SEL_RING;
                else                        rsel = SEL_INJ;
                case (rsel)
                    SEL_RING: od = head[PXM];
                    SEL_INJ:  od = head[PLOC];
                    default:  od = xb;
                endcase
            end else if (o == PLOC) begin
                od = st_q.byp[o] ? head[PXM] : xb;
            end
            if (st_q.busy[o] && !empty[src]) begin
                pop[src]   = 1'b1;
                st_d.ov[o] = 1'b1;
                st_d.od[o] = od;
                if (ends_pkt(sd[FLIT_W-1 -: 2])) begin
                    st_d.busy[o] = 1'b0;
                end
            end
            if (gnt_any[o]) begin
                st_d.busy[o]  = 1'b1;
                st_d.owner[o] = gnt_idx[o];
                st_d.byp[o]   = r_byp[gnt_idx[o]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.ov;
    assign out_data_o  = st_q.od;
    assign idle        = (&empty) && !(|st_q.busy);

    // Assertions
    for (genvar g = 0; g < NP; g++) begin : g_chk
        AST_BYPASS_ONLY_FAULTED: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.busy[g] && st_q.byp[g] |-> fault_i[g] || fault_i[NP]); // R5
        AST_TAIL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.busy[g]) |-> out_valid_o[g] && ends_pkt(out_data_o[g*FLIT_W+FLIT_W-1 -: 2])); // R3
        AST_ONE_OUTPUT_PER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_m[g])); // R3
    end

    AST_FAULT_CHANGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_i) |-> $past(idle)); // R11
    AST_RING_BEFORE_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any[PXP] && (gnt_idx[PXP] == IW'(PLOC)) |-> !(head_ok[PXM] && (r_out[PXM] == IW'(PXP)))); // R10

endmodule

// File: tb/tb_dbp_router.sv
module tb_dbp_router;

    localparam int NP = 5;
    localparam int FW = 64;
    localparam int MX = 2;
    localparam int MY = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic [NP:0]       fault;
    logic              drv_v [NP];
    logic [FW-1:0]     drv_d [NP];
    logic [NP-1:0]     in_valid, in_ready, out_valid;
    logic [NP*FW-1:0]  in_data, out_data;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            in_valid[p]          = drv_v[p];
            in_data[p*FW +: FW]  = drv_d[p];
        end
    end

    dbp_router dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_i     (fault),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_ready_o  (in_ready),
        .out_valid_o (out_valid),
        .out_data_o  (out_data)
    );

    int            checks = 0;
    int            fails  = 0;
    string         cur_req = "R4";
    logic [FW-1:0] exp_q [NP*NP][$];
    int            cur_src [NP];
    int            first_src0 = -1;
    logic          mon_en = 1'b0;
    int            seqn = 0;

    task automatic fail(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        fails++;
    endtask

    function automatic int xy_dir(input int dx, input int dy);
        if (dx > MX) return 0;
        if (dx < MX) return 1;
        if (dy > MY) return 2;
        if (dy < MY) return 3;
        return 4;
    endfunction

    // Output predicted from the routing and fault rules (R2, R5-R8)
    function automatic int exp_out(input int src, input int dx, input int dy, input logic [NP:0] f);
        int o;
        logic blocked;
        o = xy_dir(dx, dy);
        blocked = f[o] || (f[NP] && (src == 4 || o == 4));
        if (!blocked) return o;
        if (src == 1 && o == 4) return 4;
        return 0;
    endfunction

    // Scoreboard compared every clock
    always @(negedge clk) begin
        if (mon_en) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o]) begin
                    logic [FW-1:0] fl, ev;
                    int key;
                    fl = out_data[o*FW +: FW];
                    if (fl[63:62] == 2'b00 || fl[63:62] == 2'b01) begin
                        cur_src[o] = int'(fl[53:51]);
                        if (o == 0 && first_src0 < 0) first_src0 = cur_src[0];
                    end else if (int'(fl[53:51]) != cur_src[o]) begin
                        checks++;
                        fail("R3", "packet interleaved on output", 64'(fl[53:51]), 64'(cur_src[o]));
                    end
                    checks++;
                    if (cur_src[o] >= NP) begin
                        fail("R4", "flit with bad source", fl, 64'd0);
                    end else begin
                        key = cur_src[o] * NP + o;
                        if (exp_q[key].size() == 0) begin
                            fail("R4", "unexpected flit", fl, 64'd0);
                        end else begin
                            ev = exp_q[key].pop_front();
                            if (fl !== ev) fail(cur_req, "flit mismatch", fl, ev);
                        end
                    end
                end
            end
        end
    end

    task automatic send_pkt(input int p, input int dx, input int dy, input int len, output int stalls);
        int key;
        logic [FW-1:0] f;
        logic rdy;
        logic [1:0] k;
        stalls = 0;
        key = p * NP + exp_out(p, dx, dy, fault);
        for (int j = 0; j < len; j++) begin
            logic acc;
            if (len == 1)            k = 2'b00;
            else if (j == 0)         k = 2'b01;
            else if (j == len - 1)   k = 2'b11;
            else                     k = 2'b10;
            f = {k, 4'(dx), 4'(dy), 3'(p), 3'b101, $urandom(), 16'(seqn)};
            seqn++;
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                drv_v[p] = 1'b1;
                drv_d[p] = f;
                rdy = in_ready[p];
                @(posedge clk);
                if (rdy) acc = 1'b1;
                else stalls++;
            end
            exp_q[key].push_back(f);
        end
        @(negedge clk);
        drv_v[p] = 1'b0;
    endtask

    task automatic run_port(input int p, input int npk);
        int st;
        for (int k = 0; k < npk; k++) begin
            int dx, dy;
            bit ok;
            ok = 1'b0;
            while (!ok) begin
                dx = 1 + int'($urandom() % 3);
                dy = 1 + int'($urandom() % 3);
                ok = !(fault[0] && (p == 0 || p == 2 || p == 3) && xy_dir(dx, dy) == 0);
            end
            repeat (int'($urandom() % 3)) @(negedge clk);
            send_pkt(p, dx, dy, 1 + int'($urandom() % 4), st);
        end
    endtask

    task automatic drain_check(input string req);
        repeat (40) @(negedge clk);
        for (int key = 0; key < NP * NP; key++) begin
            checks++;
            if (exp_q[key].size() != 0)
                fail(req, "flits not delivered", 64'(exp_q[key].size()), 64'd0);
        end
    endtask

    task automatic phase(input logic [NP:0] f, input string req, input int npk);
        @(negedge clk);
        fault   = f;
        cur_req = req;
        fork
            run_port(0, npk);
            run_port(1, npk);
            run_port(2, npk);
            run_port(3, npk);
            run_port(4, npk);
        join
        drain_check(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fail("WATCHDOG", "run did not finish", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s1, s2;
        rst_n = 1'b0;
        fault = '0;
        for (int p = 0; p < NP; p++) begin
            drv_v[p] = 1'b0;
            drv_d[p] = '0;
            cur_src[p] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        checks++;
        if (out_valid !== 5'b00000) fail("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        checks++;
        if (in_ready !== 5'b11111) fail("R1", "in_ready after reset", 64'(in_ready), 64'h1f);
        mon_en = 1'b1;

        // R2 R3 R4: healthy routing, random traffic on all inputs
        phase(6'b000000, "R2", 6);

        // R5: X+ crossbar path dead
        phase(6'b000001, "R5", 6);

        // R10: X- and local heads for X+ arrive together
        cur_req = "R10";
        first_src0 = -1;
        fork
            send_pkt(1, 3, 2, 2, s1);
            send_pkt(4, 3, 1, 3, s2);
        join
        drain_check("R10");
        checks++;
        if (first_src0 != 1) fail("R10", "first packet on X+ not from X-", 64'(first_src0), 64'd1);

        // R7: Y+ path dead, heads diverted to X+
        phase(6'b000100, "R7", 6);

        // R8: local output path dead, X- ejection bypass
        phase(6'b010000, "R8", 5);
        send_pkt(1, 2, 2, 3, s1);
        drain_check("R8");

        // R6: local interface dead
        phase(6'b100000, "R6", 5);
        send_pkt(1, 2, 2, 2, s1);
        send_pkt(4, 1, 2, 3, s1);
        drain_check("R6");

        // R11: faults cleared while idle, routing returns to normal
        phase(6'b000000, "R11", 4);

        // R9: local input backs up behind a long packet holding X+
        cur_req = "R9";
        fork
            send_pkt(2, 3, 2, 12, s1);
            begin
                repeat (3) @(negedge clk);
                send_pkt(4, 3, 2, 8, s2);
            end
        join
        drain_check("R9");
        checks++;
        if (s2 == 0) fail("R9", "local input never back-pressured", 64'(s2), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule